// File: doc/BRIEF.md
# Select-Framed SPI Byte Slave

This block is the slave end of an SPI link, clocked entirely by the system clock. The serial clock, the data input and the active-low select from the master each pass through a two-flop synchronizer. Edges of the serial clock are then found by comparing successive synchronized samples. Each select frame carries one byte in each direction, most significant bit first. The block samples the incoming data line on the rising serial clock edge and advances its outgoing bit on the falling edge. The first outgoing bit appears on the data output as soon as the select goes low.

A received byte is not handed to the host when its eighth bit arrives. It is handed over when the select returns high, and only if the frame held exactly eight rising clock edges. A commit produces a one-cycle valid pulse and updates the receive byte. The host acknowledges the byte with a read strobe. A commit that arrives before the previous byte was acknowledged sets a sticky overrun flag, and the newer byte replaces the older one.

Between frames the host may load the next outgoing byte. The select must then stay high for a minimum number of system clocks before the next frame begins. A shorter gap sets a sticky error flag. The data output is driven only while the block is selected; otherwise its output enable is low.

Top module: `spi_byte_slave`

## Requirements
- R1: Bits on both data lines travel most significant bit first. The incoming bit is sampled on a rising serial clock edge, and the outgoing bit advances on each falling edge.
- R2: `miso_oe` is 1 while the synchronized select is low and 0 while it is high. The outgoing byte's top bit is on `miso_o` before the first rising serial clock edge of the frame.
- R3: When the select rises after exactly 8 rising serial clock edges, `rx_byte` takes the shifted-in byte and `rx_valid` is 1 for exactly one cycle. `rx_byte` does not change at any other time.
- R4: A frame with any count of rising serial clock edges other than 8 produces no `rx_valid` and leaves `rx_byte` unchanged.
- R5: A commit while the previous byte is unacknowledged (`rx_ack` not pulsed since the last commit) sets `overrun`. `overrun` stays set until reset, and the newer byte is kept in `rx_byte`.
- R6: A `tx_load` pulse while the select is high stores `tx_byte` for the next frame. A `tx_load` pulse while the select is low is ignored.
- R7: A frame that starts without a byte loaded since the previous frame began sends 0x00.
- R8: If the select falls after being high for fewer than MIN_GAP system clocks, `gap_err` is set and stays set until reset. A gap of MIN_GAP clocks or more does not set it. The gap before the first frame after reset counts as long enough.
- R9: After reset, `miso_oe`, `rx_valid`, `overrun` and `gap_err` are 0 and `rx_byte` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data from the master |
| sel_n_i | input | 1 | Active-low select from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for `miso_o` |
| tx_load | input | 1 | Strobe that stores `tx_byte` while deselected |
| tx_byte | input | DATA_W | Byte to send in the next frame |
| rx_byte | output | DATA_W | Last committed received byte |
| rx_valid | output | 1 | One-cycle pulse when `rx_byte` is committed |
| rx_ack | input | 1 | Host strobe that acknowledges `rx_byte` |
| overrun | output | 1 | Sticky flag for an unacknowledged byte being overwritten |
| gap_err | output | 1 | Sticky flag for a select gap that is too short |

## Verification
The bench uses the default parameters: an 8-bit byte and a minimum gap of 4 system clocks. With these values a serial clock half-period of 4 system clocks keeps the required 4:1 clock ratio. A 4-clock gap falls exactly on the legal boundary, and a 2-clock gap is a short gap that still lets the synchronized select go high, commit the byte and fall again. The small byte width keeps frames short, so partial frames, unloaded frames, overwritten bytes and both gap cases all fit in one run.

// File: rtl/spi_byte_slave.sv
module spi_byte_slave #(
  parameter int DATA_W  = 8,
  parameter int MIN_GAP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              sel_n_i,
  output logic              miso_o,
  output logic              miso_oe,
  input  logic              tx_load,
  input  logic [DATA_W-1:0] tx_byte,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_valid,
  input  logic              rx_ack,
  output logic              overrun,
  output logic              gap_err
);
  localparam int CW = $clog2(DATA_W + 2);
  localparam int GW = $clog2(MIN_GAP + 1);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [GW-1:0] GMIN = GW'(MIN_GAP);

  logic [1:0] sck_m, mosi_m, sel_m;
  logic       sck_q, sel_q;
  logic [DATA_W-1:0] rx_sh, tx_sh, tx_hold;
  logic [CW-1:0] bit_cnt;
  logic [GW-1:0] gap_cnt;
  logic rx_full;

  wire sck_s = sck_m[1];
  wire sel_s = sel_m[1];
  wire rise_evt = ~sel_s & sck_s & ~sck_q;
  wire fall_evt = ~sel_s & ~sck_s & sck_q;
  wire sel_fall = sel_q & ~sel_s;
  wire sel_rise = ~sel_q & sel_s;
  wire commit   = sel_rise && bit_cnt == CW'(DATA_W);

  assign miso_o = tx_sh[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_m <= '0; mosi_m <= '0; sel_m <= '1;
      sck_q <= 1'b0; sel_q <= 1'b1;
    end else begin
      sck_m <= {sck_m[0], sck_i};
      mosi_m <= {mosi_m[0], mosi_i};
      sel_m <= {sel_m[0], sel_n_i};
      sck_q <= sck_s;
      sel_q <= sel_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh <= '0; tx_sh <= '0; tx_hold <= '0; bit_cnt <= '0;
    end else begin
      if (sel_s) begin
        bit_cnt <= '0;
        tx_sh <= tx_hold;
        if (tx_load) tx_hold <= tx_byte;
      end else begin
        if (sel_fall) tx_hold <= '0;
        if (rise_evt) begin
          rx_sh <= {rx_sh[DATA_W-2:0], mosi_m[1]};
          if (bit_cnt != CMAX) bit_cnt <= bit_cnt + 1'b1;
        end
        if (fall_evt) tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte <= '0; rx_valid <= 1'b0; rx_full <= 1'b0;
      overrun <= 1'b0; gap_err <= 1'b0; miso_oe <= 1'b0;
      gap_cnt <= GMIN;
    end else begin
      miso_oe <= ~sel_s;
      rx_valid <= commit;
      if (commit) begin
        rx_byte <= rx_sh;
        rx_full <= 1'b1;
        if (rx_full && !rx_ack) overrun <= 1'b1;
      end else if (rx_ack) begin
        rx_full <= 1'b0;
      end
      if (!sel_s) gap_cnt <= '0;
      else if (gap_cnt != GMIN) gap_cnt <= gap_cnt + 1'b1;
      if (sel_fall && gap_cnt < GMIN) gap_err <= 1'b1;
    end
  end
endmodule

module spi_byte_slave_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miso_o,
  input logic              miso_oe,
  input logic              fall_evt,
  input logic [DATA_W-1:0] rx_byte,
  input logic              rx_valid,
  input logic              overrun,
  input logic              gap_err
);
  assert_commit_deselected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !miso_oe);
  assert_valid_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  assert_rx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_byte));
  assert_overrun_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  assert_overrun_on_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> rx_valid);
  assert_gap_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gap_err |=> gap_err);
  assert_gap_on_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gap_err) |-> $rose(miso_oe));
  assert_miso_steady_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (miso_oe && $past(miso_oe) && !$past(fall_evt)) |-> $stable(miso_o));
endmodule

bind spi_byte_slave spi_byte_slave_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .miso_o(miso_o), .miso_oe(miso_oe),
  .fall_evt(fall_evt), .rx_byte(rx_byte), .rx_valid(rx_valid),
  .overrun(overrun), .gap_err(gap_err)
);

// File: tb/spi_byte_slave_bench.sv
module spi_byte_slave_bench;
  localparam int CLK_P = 10;
  localparam int HALF  = 4;

  logic clk = 0, rst_n = 0;
  logic sck_i = 0, mosi_i = 0, sel_n_i = 1;
  logic tx_load = 0, rx_ack = 0;
  logic [7:0] tx_byte = '0;
  logic miso_o, miso_oe, rx_valid, overrun, gap_err;
  logic [7:0] rx_byte;

  int applied = 0, bad = 0;
  bit auto_ack = 1;
  logic [7:0] exp_q[$];

  spi_byte_slave u_spi_byte_slave (
    .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .mosi_i(mosi_i), .sel_n_i(sel_n_i),
    .miso_o(miso_o), .miso_oe(miso_oe), .tx_load(tx_load), .tx_byte(tx_byte),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ack(rx_ack),
    .overrun(overrun), .gap_err(gap_err)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [7:0] b);
    @(negedge clk); tx_load = 1; tx_byte = b;
    @(negedge clk); tx_load = 0;
  endtask

  task automatic frame(input logic [7:0] mo, input logic [7:0] exp_miso,
                       input int nbits, input bit mid_load, input int gap);
    logic [7:0] got;
    got = '0;
    @(negedge clk); sel_n_i = 0;
    wait_n(HALF);
    check("R2 oe while selected", {7'b0, miso_oe}, 8'h01);
    if (mid_load) load(8'h77);
    for (int i = 0; i < nbits; i++) begin
      mosi_i = mo[7-i];
      wait_n(HALF);
      got[7-i] = miso_o;
      sck_i = 1;
      wait_n(HALF);
      sck_i = 0;
      wait_n(HALF);
    end
    if (nbits == 8) begin
      check("R1/R6/R7 miso byte", got, exp_miso);
      exp_q.push_back(mo);
    end
    sel_n_i = 1;
    wait_n(gap);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      rx_ack = rx_valid && auto_ack;
      if (rx_valid) begin
        if (exp_q.size() == 0) check("R4 unexpected rx_valid", 8'h01, 8'h00);
        else check("R3 rx_byte", rx_byte, exp_q.pop_front());
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1;
    wait_n(2);
    check("R9 oe", {7'b0, miso_oe}, 8'h00);
    check("R9 valid", {7'b0, rx_valid}, 8'h00);
    check("R9 overrun", {7'b0, overrun}, 8'h00);
    check("R9 gap_err", {7'b0, gap_err}, 8'h00);
    check("R9 rx_byte", rx_byte, 8'h00);

    load(8'h3C); wait_n(4);
    frame(8'hA5, 8'h3C, 8, 0, 10);
    load(8'h81); wait_n(4);
    frame(8'hFF, 8'h81, 8, 0, 10);
    frame(8'h00, 8'h00, 8, 0, 10);
    load(8'hC3); wait_n(4);
    frame(8'h5A, 8'hC3, 8, 0, 10);
    check("R2 oe after deselect", {7'b0, miso_oe}, 8'h00);

    frame(8'h9E, 8'h00, 5, 0, 10);
    wait_n(6);
    check("R4 rx_byte after partial", rx_byte, 8'h5A);
    frame(8'h12, 8'h00, 8, 0, 10);
    wait_n(4);
    check("R4 queue drained", 8'(exp_q.size()), 8'h00);

    frame(8'h34, 8'h00, 8, 1, 10);
    frame(8'h56, 8'h00, 8, 0, 10);

    check("R5 no overrun with acks", {7'b0, overrun}, 8'h00);
    auto_ack = 0;
    frame(8'h6B, 8'h00, 8, 0, 10);
    frame(8'hD2, 8'h00, 8, 0, 10);
    wait_n(4);
    check("R5 overrun set", {7'b0, overrun}, 8'h01);
    check("R5 newer byte kept", rx_byte, 8'hD2);
    auto_ack = 1;
    wait_n(4);
    check("R5 overrun sticky", {7'b0, overrun}, 8'h01);

    check("R8 no gap_err yet", {7'b0, gap_err}, 8'h00);
    frame(8'h11, 8'h00, 8, 0, 4);
    frame(8'h22, 8'h00, 8, 0, 10);
    check("R8 gap of MIN_GAP ok", {7'b0, gap_err}, 8'h00);
    frame(8'h33, 8'h00, 8, 0, 2);
    frame(8'h44, 8'h00, 8, 0, 10);
    check("R8 short gap flagged", {7'b0, gap_err}, 8'h01);
    wait_n(10);
    check("R8 gap_err sticky", {7'b0, gap_err}, 8'h01);
    check("R3 all bytes seen", 8'(exp_q.size()), 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule